// File: doc/BRIEF.md
# Timer Event Flag and Request Unit

This unit gathers the event flags of one channel of a 16-bit counter that carries several compare/capture units. The counter and the compare/capture logic deliver one-cycle strobes. The unit latches them into sticky flags and combines the flags with software-programmed enables. From this it drives a single interrupt line and one transfer request line per DMA channel.

A small register port gives software three things. It can read the flags and clear them by writing ones. It can program the interrupt enables. It can program, for each DMA channel, a mask of the flags that may raise that channel's request.

The compare/capture, counter-maximum and counter-zero flags serve two roles. Software may clear them, and a DMA channel that accepts its request also clears the flags behind that request. The register logic refuses any write that would give one flag both an interrupt enable and a DMA enable.

Top module: `tmr_evt_req`

## Requirements
- R1: Flag word at offset 0, bit m (m < NCC): the compare/capture flag of unit m. It sets on the clock edge that samples `cc_match[m]` or `cc_capture[m]` high.
- R2: Flag word bit NCC+m: the overwrite flag of unit m. It sets when `cc_capture[m]` is sampled while compare/capture flag m is already 1. A capture into a clear unit leaves it untouched.
- R3: Flag word bit 2*NCC: the maximum flag. It sets on `evt_max` only while `cnt_mode` is 0 (up) or 2 (up/down). In mode 1 (down) and mode 3 (idle) the strobe is ignored.
- R4: Flag word bit 2*NCC+1: the zero flag. It sets on `evt_zero` only while `cnt_mode` is 1 (down).
- R5: A write to offset 0 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R6: The interrupt enable word sits at offset 1 and uses the flag word's layout. `irq` is registered. It is high exactly when some flag and its enable are both 1, and it changes on the same edge as the flags.
- R7: The DMA enable word of channel d sits at offset 2+d. Bits 0..NCC-1 select the compare/capture flags, bit NCC the maximum flag and bit NCC+1 the zero flag. `dma_req[d]` is registered and is high exactly when an enabled source flag is set.
- R8: `dma_ack[d]` high on an edge clears the source flags enabled for channel d. Flags that channel d does not enable are left alone.
- R9: A write to the interrupt enable word, or to a DMA enable word, is dropped whole if it would leave one source with both an interrupt enable and a DMA enable. The register keeps its old value.
- R10: When a set event and a software write-one clear hit the same flag on the same edge, the flag ends up set.
- R11: When a set event and a DMA accept hit the same flag on the same edge, the flag ends up set.
- R12: After reset all flags and enables read 0, and `irq` and `dma_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_mode | input | 2 | Count mode: 0 up, 1 down, 2 up/down, 3 idle |
| cc_match | input | NCC | Comparator equal strobe per unit |
| cc_capture | input | NCC | Capture load strobe per unit |
| evt_max | input | 1 | Counter reached its maximum |
| evt_zero | input | 1 | Counter reached zero |
| bus_addr | input | AW | Register offset |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, 0 at unmapped offsets |
| dma_ack | input | NDMA | Request accepted, per DMA channel |
| irq | output | 1 | Interrupt request |
| dma_req | output | NDMA | Transfer request per DMA channel |

## Verification
The bench sends a capture into a unit whose flag is already set, and a capture into a clear unit. A design that ignored the old flag state would either miss the overwrite or report one falsely. Maximum and zero strobes are applied in every count mode, so a mode decode that is too loose shows up as a wrong flag.

Set events are timed to land on the same edge as a write-one clear, and again on the same edge as a DMA accept. A design that let the clear win would lose the event and drop its request.

An accept is applied while a flag that the channel does not enable is also set. Clearing every flag on accept would wipe that flag.

Enable writes that would cause a conflict are issued in both directions, from the interrupt side and from the DMA side. A design that accepted them would show an enable that can be read back, or a request or interrupt that should not be there.

// File: rtl/tmr_evt_req.sv
module tmr_evt_req #(
  parameter int NCC  = 2,
  parameter int NDMA = 4,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NDMA + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cnt_mode,
  input  logic [NCC-1:0]  cc_match,
  input  logic [NCC-1:0]  cc_capture,
  input  logic            evt_max,
  input  logic            evt_zero,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wen,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NDMA-1:0] dma_ack,
  output logic            irq,
  output logic [NDMA-1:0] dma_req
);
  localparam int NF = 2 * NCC + 2;
  localparam int NS = NCC + 2;
  localparam logic [1:0] M_UP = 2'd0, M_DN = 2'd1, M_UD = 2'd2;

  logic [NF-1:0]            flag_q, flag_d, ien_q, ien_d, set_v, sw_clr, ack_clr;
  logic [NDMA-1:0][NS-1:0]  dma_en_q, dma_en_d;
  logic [NS-1:0]            src_q, src_d, ien_src, new_src, dma_any, ack_src;
  logic [NDMA-1:0]          req_d;
  logic                     set_mx, set_zr, wr_flag, wr_ien;

  assign src_q   = {flag_q[NF-1:NF-2], flag_q[NCC-1:0]};
  assign src_d   = {flag_d[NF-1:NF-2], flag_d[NCC-1:0]};
  assign ien_src = {ien_q[NF-1:NF-2], ien_q[NCC-1:0]};

  assign set_mx = evt_max && (cnt_mode == M_UP || cnt_mode == M_UD);
  assign set_zr = evt_zero && (cnt_mode == M_DN);
  assign set_v  = {set_zr, set_mx, cc_capture & flag_q[NCC-1:0], cc_match | cc_capture};

  assign wr_flag = bus_wen && (bus_addr == AW'(0));
  assign wr_ien  = bus_wen && (bus_addr == AW'(1));
  assign sw_clr  = wr_flag ? bus_wdata[NF-1:0] : '0;

  always_comb begin
    ack_src = '0;
    dma_any = '0;
    for (int d = 0; d < NDMA; d++) begin
      dma_any = dma_any | dma_en_q[d];
      if (dma_ack[d]) ack_src = ack_src | (src_q & dma_en_q[d]);
    end
  end

  assign ack_clr = {ack_src[NS-1:NCC], {NCC{1'b0}}, ack_src[NCC-1:0]};
  assign flag_d  = (flag_q & ~(sw_clr | ack_clr)) | set_v;

  assign new_src = {bus_wdata[NF-1:NF-2], bus_wdata[NCC-1:0]};
  assign ien_d   = (wr_ien && (new_src & dma_any) == '0) ? bus_wdata[NF-1:0] : ien_q;

  for (genvar d = 0; d < NDMA; d++) begin : g_ch
    logic wr_ch;
    assign wr_ch       = bus_wen && (bus_addr == AW'(d + 2));
    assign dma_en_d[d] = (wr_ch && (bus_wdata[NS-1:0] & ien_src) == '0) ? bus_wdata[NS-1:0]
                                                                       : dma_en_q[d];
    assign req_d[d]    = |(src_d & dma_en_d[d]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      ien_q    <= '0;
      dma_en_q <= '0;
      irq      <= 1'b0;
      dma_req  <= '0;
    end else begin
      flag_q   <= flag_d;
      ien_q    <= ien_d;
      dma_en_q <= dma_en_d;
      irq      <= |(flag_d & ien_d);
      dma_req  <= req_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0))      bus_rdata[NF-1:0] = flag_q;
    else if (bus_addr == AW'(1)) bus_rdata[NF-1:0] = ien_q;
    else
      for (int d = 0; d < NDMA; d++)
        if (bus_addr == AW'(d + 2)) bus_rdata[NS-1:0] = dma_en_q[d];
  end
endmodule

module tmr_evt_req_chk #(
  parameter int NCC  = 2,
  parameter int NDMA = 4,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NDMA + 2),
  localparam int NF  = 2 * NCC + 2,
  localparam int NS  = NCC + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              cnt_mode,
  input logic [NCC-1:0]          cc_match,
  input logic [NCC-1:0]          cc_capture,
  input logic                    evt_max,
  input logic                    evt_zero,
  input logic [AW-1:0]           bus_addr,
  input logic                    bus_wen,
  input logic [DW-1:0]           bus_wdata,
  input logic                    irq,
  input logic [NDMA-1:0]         dma_req,
  input logic [NF-1:0]           flag_q,
  input logic [NF-1:0]           ien_q,
  input logic [NDMA-1:0][NS-1:0] dma_en_q
);
  logic [NS-1:0] s_src, s_ien, s_any;
  always_comb begin
    s_src = {flag_q[NF-1:NF-2], flag_q[NCC-1:0]};
    s_ien = {ien_q[NF-1:NF-2], ien_q[NCC-1:0]};
    s_any = '0;
    for (int d = 0; d < NDMA; d++) s_any = s_any | dma_en_q[d];
  end

  AST_CC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cc_match[0] |=> flag_q[0]); // R1
  AST_OVW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[NCC]) |-> $past(cc_capture[0] && flag_q[0])); // R2
  AST_MAX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2*NCC]) |-> $past(evt_max && (cnt_mode == 2'd0 || cnt_mode == 2'd2))); // R3
  AST_ZERO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2*NCC+1]) |-> $past(evt_zero && cnt_mode == 2'd1)); // R4
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == AW'(0) && bus_wdata[0] && !cc_match[0] && !cc_capture[0])
    |=> !flag_q[0]); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(flag_q & ien_q)); // R6
  AST_DMA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[0] == |(s_src & dma_en_q[0])); // R7
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ien & s_any) == '0); // R9
endmodule

bind tmr_evt_req tmr_evt_req_chk #(.NCC(NCC), .NDMA(NDMA), .DW(DW)) u_chk (.*);

// File: tb/tmr_evt_req_tb.sv
module tmr_evt_req_tb;
  localparam int CLK_P = 10;
  localparam int NCC = 2, NDMA = 4, DW = 16, AW = $clog2(NDMA + 2);

  logic clk = 0, rst_n = 0;
  logic [1:0] cnt_mode = 0;
  logic [NCC-1:0] cc_match = 0, cc_capture = 0;
  logic evt_max = 0, evt_zero = 0, bus_wen = 0, irq;
  logic [AW-1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic [NDMA-1:0] dma_ack = 0, dma_req;

  int checks = 0, fails = 0;
  bit done = 0;
  int    sel_q[$];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  tmr_evt_req #(.NCC(NCC), .NDMA(NDMA), .DW(DW)) u_dut (.*);

  task automatic apply(input logic [NCC-1:0] m, input logic [NCC-1:0] cap, input logic mx,
                       input logic zr, input logic [1:0] mode, input logic we, input int a,
                       input logic [DW-1:0] wd, input logic [NDMA-1:0] acc);
    @(negedge clk); #1;
    cc_match = m; cc_capture = cap; evt_max = mx; evt_zero = zr; cnt_mode = mode;
    bus_wen = we; bus_addr = AW'(a); bus_wdata = wd; dma_ack = acc;
    @(posedge clk); #1;
  endtask

  // sel: 0 = bus_rdata, 1 = irq, 2 = dma_req
  task automatic expect_item(input int sel, input logic [31:0] val, input string tag);
    sel_q.push_back(sel); exp_q.push_back(val); tag_q.push_back(tag);
  endtask

  task automatic rd(input int a);
    apply(0, 0, 0, 0, 0, 0, a, 0, 0);
  endtask

  always @(negedge clk) begin
    int s; logic [31:0] e, act; string t;
    while (sel_q.size() > 0) begin
      s = sel_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      act = (s == 0) ? 32'(bus_rdata) : (s == 1) ? 32'(irq) : 32'(dma_req);
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s: sel %0d actual 0x%0h expected 0x%0h", t, s, act, e);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3); rst_n = 1;
    rd(0); expect_item(0, 0, "R12 flags"); expect_item(1, 0, "R12 irq"); expect_item(2, 0, "R12 dma");
    rd(1); expect_item(0, 0, "R12 ien");
    rd(2); expect_item(0, 0, "R12 dma en");

    apply(2'b01, 0, 0, 0, 0, 0, 0, 0, 0); expect_item(0, 'h01, "R1 match"); expect_item(1, 0, "R6 disabled");
    apply(0, 0, 0, 0, 0, 1, 1, 'h01, 0); expect_item(1, 1, "R6 irq on");
    apply(0, 0, 0, 0, 0, 1, 0, 'h00, 0); expect_item(1, 1, "R5 write zero");
    rd(0); expect_item(0, 'h01, "R5 zero no effect");
    apply(0, 0, 0, 0, 0, 1, 0, 'h01, 0); expect_item(1, 0, "R6 irq off");
    rd(0); expect_item(0, 'h00, "R5 cleared");

    apply(0, 2'b10, 0, 0, 0, 0, 0, 0, 0); expect_item(0, 'h02, "R1 capture");
    apply(0, 2'b10, 0, 0, 0, 0, 0, 0, 0); expect_item(0, 'h0A, "R2 overwrite");
    apply(0, 2'b01, 0, 0, 0, 0, 0, 0, 0); expect_item(0, 'h0B, "R2 no overwrite");
    apply(0, 0, 0, 0, 0, 1, 0, 'h3F, 0); expect_item(0, 'h00, "R5 clear all");

    apply(0, 0, 1, 0, 2'd0, 0, 0, 0, 0); expect_item(0, 'h10, "R3 up");
    apply(0, 0, 0, 1, 2'd0, 0, 0, 0, 0); expect_item(0, 'h10, "R4 up ignored");
    apply(0, 0, 0, 1, 2'd1, 0, 0, 0, 0); expect_item(0, 'h30, "R4 down");
    apply(0, 0, 1, 0, 2'd1, 0, 0, 0, 0); expect_item(0, 'h30, "R3 down ignored");
    apply(0, 0, 0, 0, 0, 1, 0, 'h3F, 0); expect_item(0, 'h00, "R5 clear");
    apply(0, 0, 1, 1, 2'd3, 0, 0, 0, 0); expect_item(0, 'h00, "R3 R4 idle ignored");
    apply(0, 0, 1, 0, 2'd2, 0, 0, 0, 0); expect_item(0, 'h10, "R3 updown");
    apply(0, 0, 0, 0, 0, 1, 0, 'h3F, 0); expect_item(0, 'h00, "R5 clear");

    apply(2'b01, 0, 0, 0, 0, 0, 0, 0, 0); expect_item(1, 1, "R6 irq");
    apply(2'b01, 0, 0, 0, 0, 1, 0, 'h01, 0); expect_item(0, 'h01, "R10 set wins");
    expect_item(1, 1, "R10 irq kept");

    apply(0, 0, 0, 0, 0, 1, 2, 'h01, 0); expect_item(0, 'h00, "R9 dma rejected");
    expect_item(2, 0, "R9 no request");
    apply(0, 0, 0, 0, 0, 1, 1, 'h00, 0); expect_item(1, 0, "R6 ien cleared");
    apply(0, 0, 0, 0, 0, 1, 2, 'h05, 0); expect_item(0, 'h05, "R9 dma accepted");
    expect_item(2, 'b0001, "R7 ch0 request");
    apply(0, 0, 0, 0, 0, 1, 1, 'h10, 0); expect_item(0, 'h00, "R9 ien rejected");
    expect_item(1, 0, "R9 irq stays low");

    apply(0, 0, 0, 0, 0, 1, 4, 'h08, 0); expect_item(0, 'h08, "R7 ch2 enable");
    expect_item(2, 'b0001, "R7 ch2 idle");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 4'b0001); expect_item(0, 'h00, "R8 accept clears");
    expect_item(2, 'b0000, "R8 request drops");

    apply(2'b01, 0, 0, 0, 0, 0, 0, 0, 0); expect_item(2, 'b0001, "R7 re-request");
    apply(2'b01, 0, 0, 0, 0, 0, 0, 0, 4'b0001); expect_item(0, 'h01, "R11 set wins");
    expect_item(2, 'b0001, "R11 request kept");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 4'b0001); expect_item(0, 'h00, "R8 accept");

    apply(0, 2'b10, 0, 1, 2'd1, 0, 0, 0, 0); expect_item(0, 'h22, "R4 R1 flags");
    expect_item(2, 'b0100, "R7 ch2 zero request");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 4'b0100); expect_item(0, 'h02, "R8 selective clear");
    expect_item(2, 'b0000, "R8 ch2 drops");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule